// File: doc/BRIEF.md
# Prioritized Local-Store Access Arbiter

This block puts four requesters in front of one single-ported local memory whose word is a 16-byte quadword. The requesters are a register-mapped I/O path, a DMA engine, a data-fetch path and an instruction-fetch path. In each free cycle one requester is granted by fixed priority. The two quadword requesters (register I/O and data fetch) move one quadword per grant. The two line requesters (DMA and instruction fetch) move a 128-byte line as eight back-to-back quadword beats. Once a line burst has started, nothing can pre-empt it.

Every requester has a valid/ready channel carrying an address, a write flag, a byte count and write data, plus its own read-response strobe. All ports share one read-data bus. A quadword-port write that covers only part of a quadword is turned inside the block into a read of that quadword, a byte merge and a write-back. The requester keeps its request up and sees only a late ready.

Top module: `ls_arbiter`

## Requirements
- R1: Port indices are 0 register I/O, 1 DMA, 2 data fetch and 3 instruction fetch. In a free cycle the lowest-indexed valid port wins, and at most one ready is high in any cycle.
- R2: A quadword-port read addresses word addr[AW-1:4]. When that port wins a free cycle, its ready is high in the same cycle.
- R3: A line-port grant runs LINE_BEATS consecutive cycles with that port's ready high in each. Beat k uses word (line base + k), and the low seven address bits are ignored. Write data is taken from each beat's cycle.
- R4: A higher-priority request that arrives during a line burst gets no ready until the burst's last beat has passed.
- R5: Exactly one cycle after each cycle in which ready and a low write flag are seen on port p, rsp_valid_o[p] is high. In that cycle rsp_rdata_o holds the addressed quadword.
- R6: A quadword-port write with offset o = addr[3:0] and length field n covers bytes o through min(o+n, 15). It replaces exactly those byte lanes with the same lanes of the write data. Bytes past lane 15 are dropped, and all other bytes keep their old values.
- R7: A write that does not cover all 16 bytes holds the memory for two cycles. The first cycle reads the word with ready low, and the second writes the merged word with ready high. No read response is produced, and no other port is served in between.
- R8: A request that loses arbitration stays pending and is served later with no loss.
- R9: After reset, with no valid input, every ready and every response strobe is low.
- R10: A quadword-port write with offset 0 and length field 15 completes in one cycle and replaces the whole quadword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 4 | Request valid, one bit per port |
| req_ready_o | output | 4 | Request/beat accepted, one bit per port |
| req_we_i | input | 4 | Write flag per port |
| req_addr_i | input | 4 x AW | Byte address per port |
| req_len_i | input | 4 x 4 | Byte count minus one (quadword ports) |
| req_wdata_i | input | 4 x DW | Write data per port, lane-aligned |
| rsp_valid_o | output | 4 | Read data valid, one bit per port |
| rsp_rdata_o | output | DW | Shared read data |

## Verification
The bench builds the block with DEPTH = 32 words (four lines), LINE_BEATS = 8 and DW = 128. With so few words, pseudo-random traffic keeps landing partial writes on words that line bursts have just written or are about to read. This exercises merges against fresh data. The small depth also puts the last line and its ignored low address bits within easy reach. All four ports are loaded at once, so there is heavy contention: requests arrive mid-burst and during the read half of a merge.

// File: rtl/ls_arb_pkg.sv
package ls_arb_pkg;
  localparam int unsigned NREQ = 4;
  // port 0 reg I/O, 1 DMA, 2 data fetch, 3 instruction fetch; bit set = line port
  localparam logic [NREQ-1:0] LINE_PORTS = 4'b1010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LINE,
    ST_RMW
  } arb_state_e;
endpackage

// File: rtl/ls_prio_pick.sv
module ls_prio_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    any_o = |req_i;
    gnt_o = any_o ? (N'(1) << idx_o) : '0;
  end
endmodule

// File: rtl/ls_byte_mask.sv
module ls_byte_mask #(
  parameter int unsigned BYTES = 16,
  localparam int unsigned OFFW = $clog2(BYTES)
) (
  input  logic [OFFW-1:0]  off_i,
  input  logic [OFFW-1:0]  len_i,
  output logic [BYTES-1:0] mask_o,
  output logic             full_o
);
  logic [OFFW:0] last;

  assign last = {1'b0, off_i} + {1'b0, len_i};

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign mask_o[k] = (k >= int'(off_i)) && (k <= int'(last));
  end

  assign full_o = &mask_o;
endmodule

// File: rtl/ls_store.sv
module ls_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 128,
  localparam int unsigned WIW  = $clog2(DEPTH)
) (
  input  logic           clk_i,
  input  logic           en_i,
  input  logic           we_i,
  input  logic [WIW-1:0] addr_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      else      rdata_o     <= mem[addr_i];
    end
  end
endmodule

// File: rtl/ls_arbiter.sv
module ls_arbiter
  import ls_arb_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned LINE_BEATS = 8,
  parameter int unsigned DW         = 128,
  localparam int unsigned BYTES     = DW / 8,
  localparam int unsigned OFFW      = $clog2(BYTES),
  localparam int unsigned WIW       = $clog2(DEPTH),
  localparam int unsigned AW        = WIW + OFFW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NREQ-1:0]           req_valid_i,
  output logic [NREQ-1:0]           req_ready_o,
  input  logic [NREQ-1:0]           req_we_i,
  input  logic [NREQ-1:0][AW-1:0]   req_addr_i,
  input  logic [NREQ-1:0][OFFW-1:0] req_len_i,
  input  logic [NREQ-1:0][DW-1:0]   req_wdata_i,
  output logic [NREQ-1:0]           rsp_valid_o,
  output logic [DW-1:0]             rsp_rdata_o
);
  localparam int unsigned BW  = $clog2(LINE_BEATS);
  localparam int unsigned LIW = WIW - BW;
  localparam int unsigned PW  = $clog2(NREQ);

  arb_state_e       state_q, state_d;
  logic [PW-1:0]    owner_q, owner_d;
  logic [BW-1:0]    beat_q, beat_d;
  logic [LIW-1:0]   line_q, line_d;
  logic [WIW-1:0]   rmw_addr_q, rmw_addr_d;
  logic [BYTES-1:0] rmw_mask_q, rmw_mask_d;
  logic [NREQ-1:0]  rsp_valid_q;

  logic [NREQ-1:0]  gnt;
  logic [PW-1:0]    win_idx;
  logic             win_any;
  logic [AW-1:0]    win_addr;
  logic [BYTES-1:0] win_mask;
  logic             win_full;

  logic             mem_en, mem_we;
  logic [WIW-1:0]   mem_addr;
  logic [DW-1:0]    mem_wdata, mem_rdata, merged;

  ls_prio_pick #(.N(NREQ)) u_pick (
    .req_i(req_valid_i), .gnt_o(gnt), .idx_o(win_idx), .any_o(win_any)
  );

  assign win_addr = req_addr_i[win_idx];

  ls_byte_mask #(.BYTES(BYTES)) u_mask (
    .off_i(win_addr[OFFW-1:0]), .len_i(req_len_i[win_idx]),
    .mask_o(win_mask), .full_o(win_full)
  );

  ls_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk_i(clk_i), .en_i(mem_en), .we_i(mem_we), .addr_i(mem_addr),
    .wdata_i(mem_wdata), .rdata_o(mem_rdata)
  );

  // old bytes from the read half, new bytes from the held request
  for (genvar k = 0; k < BYTES; k++) begin : g_merge
    assign merged[8*k +: 8] = rmw_mask_q[k] ? req_wdata_i[owner_q][8*k +: 8]
                                            : mem_rdata[8*k +: 8];
  end

  always_comb begin
    state_d     = state_q;
    owner_d     = owner_q;
    beat_d      = beat_q;
    line_d      = line_q;
    rmw_addr_d  = rmw_addr_q;
    rmw_mask_d  = rmw_mask_q;
    mem_en      = 1'b0;
    mem_we      = 1'b0;
    mem_addr    = '0;
    mem_wdata   = '0;
    req_ready_o = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (win_any) begin
          mem_en  = 1'b1;
          owner_d = win_idx;
          if (LINE_PORTS[win_idx]) begin
            line_d      = win_addr[AW-1 -: LIW];
            mem_we      = req_we_i[win_idx];
            mem_addr    = {win_addr[AW-1 -: LIW], BW'(0)};
            mem_wdata   = req_wdata_i[win_idx];
            req_ready_o = gnt;
            beat_d      = BW'(1);
            state_d     = ST_LINE;
          end else if (req_we_i[win_idx] && !win_full) begin
            mem_addr   = win_addr[AW-1:OFFW];
            rmw_addr_d = win_addr[AW-1:OFFW];
            rmw_mask_d = win_mask;
            state_d    = ST_RMW;
          end else begin
            mem_we      = req_we_i[win_idx];
            mem_addr    = win_addr[AW-1:OFFW];
            mem_wdata   = req_wdata_i[win_idx];
            req_ready_o = gnt;
          end
        end
      end
      ST_LINE: begin
        mem_en               = 1'b1;
        mem_we               = req_we_i[owner_q];
        mem_addr             = {line_q, beat_q};
        mem_wdata            = req_wdata_i[owner_q];
        req_ready_o[owner_q] = 1'b1;
        beat_d               = beat_q + BW'(1);
        if (beat_q == BW'(LINE_BEATS - 1)) state_d = ST_IDLE;
      end
      ST_RMW: begin
        mem_en               = 1'b1;
        mem_we               = 1'b1;
        mem_addr             = rmw_addr_q;
        mem_wdata            = merged;
        req_ready_o[owner_q] = 1'b1;
        state_d              = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      owner_q     <= '0;
      beat_q      <= '0;
      line_q      <= '0;
      rmw_addr_q  <= '0;
      rmw_mask_q  <= '0;
      rsp_valid_q <= '0;
    end else begin
      state_q     <= state_d;
      owner_q     <= owner_d;
      beat_q      <= beat_d;
      line_q      <= line_d;
      rmw_addr_q  <= rmw_addr_d;
      rmw_mask_q  <= rmw_mask_d;
      rsp_valid_q <= req_ready_o & ~req_we_i;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = mem_rdata;

  a_r1_one_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));

  a_r1_io_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i[0]) |->
      (req_ready_o[0] || (mem_en && !mem_we && owner_d == '0)));

  a_r4_no_preempt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LINE) |-> $stable(req_ready_o));

  a_r5_rsp_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o != '0) |-> $past(mem_en && !mem_we));

  a_r7_rmw_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RMW) |->
      (mem_we && $past(mem_en && !mem_we) && mem_addr == $past(mem_addr)));

  a_r8_ready_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
endmodule

// File: tb/ls_arbiter_bench.sv
`timescale 1ns/1ps
module ls_arbiter_bench;
  localparam int NREQ  = 4;
  localparam int DEPTH = 32;
  localparam int LB    = 8;
  localparam int DW    = 128;
  localparam int AW    = $clog2(DEPTH) + 4;

  typedef struct {
    bit             we;
    int             addr;
    int             len;
    logic [DW-1:0]  seed;
  } txn_t;

  logic                    clk = 1'b0;
  logic                    rst_ni;
  logic [NREQ-1:0]         valid, ready, we, rsp_valid;
  logic [NREQ-1:0][AW-1:0] addr;
  logic [NREQ-1:0][3:0]    len;
  logic [NREQ-1:0][DW-1:0] wdata;
  logic [DW-1:0]           rsp_rdata;

  always #2.5 clk = ~clk;

  ls_arbiter #(.DEPTH(DEPTH), .LINE_BEATS(LB), .DW(DW)) u_ls_arbiter (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(ready),
    .req_we_i(we), .req_addr_i(addr), .req_len_i(len), .req_wdata_i(wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata)
  );

  int checks = 0, errors = 0;
  txn_t q [NREQ][$];
  int beatc [NREQ];

  logic [DW-1:0] mmem [DEPTH];
  string         wtag [DEPTH];
  int            m_state = 0, m_owner = 0, m_beat = 0, m_base = 0, m_word = 0;
  logic [15:0]   m_mask;
  logic [NREQ-1:0] exp_rv = '0;
  logic [DW-1:0] exp_rd;
  string         exp_rtag = "R5";
  logic [31:0]   lfsr = 32'hACE1_2345;

  function automatic bit is_line(int p);
    return (p == 1) || (p == 3);
  endfunction

  function automatic logic [DW-1:0] beat_data(txn_t t, int b);
    return t.seed ^ {16{8'(b * 37 + 1)}};
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr;
  endfunction

  function automatic void push(int p, bit w, int a, int n, logic [DW-1:0] s);
    txn_t t;
    t.we = w; t.addr = a; t.len = n; t.seed = s;
    q[p].push_back(t);
  endfunction

  task automatic check(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(int p, int word, bit w, logic [DW-1:0] d, string t,
                       inout logic [NREQ-1:0] nrv);
    if (w) begin
      mmem[word] = d;
      wtag[word] = t;
    end else begin
      nrv[p]   = 1'b1;
      exp_rd   = mmem[word];
      exp_rtag = wtag[word];
    end
  endtask

  task automatic step();
    logic [NREQ-1:0] er, nrv;
    string tag;
    int word, off, win;
    logic [15:0] mk;
    logic [DW-1:0] mg;
    @(negedge clk);
    for (int p = 0; p < NREQ; p++) begin
      valid[p] = q[p].size() > 0;
      if (valid[p]) begin
        we[p]    = q[p][0].we;
        addr[p]  = AW'(q[p][0].addr);
        len[p]   = 4'(q[p][0].len);
        wdata[p] = beat_data(q[p][0], beatc[p]);
      end else begin
        we[p] = 1'b0; addr[p] = '0; len[p] = '0; wdata[p] = '0;
      end
    end
    #1;
    check(rsp_valid === exp_rv, "R5", "rsp_valid", DW'(rsp_valid), DW'(exp_rv));
    if (exp_rv != '0) check(rsp_rdata === exp_rd, exp_rtag, "rdata", rsp_rdata, exp_rd);
    er = '0; nrv = '0; tag = "R9";
    case (m_state)
      0: begin
        win = -1;
        for (int p = NREQ - 1; p >= 0; p--) if (valid[p]) win = p;
        if (win >= 0) begin
          if (is_line(win)) begin
            tag = ($countones(valid) > 1) ? "R1" : "R3";
            m_base = ((addr[win] >> 4) / LB) * LB;
            er[win] = 1'b1; m_owner = win; m_beat = 1; m_state = 1;
            do_op(win, m_base, we[win], wdata[win], "R3", nrv);
          end else begin
            word = int'(addr[win]) >> 4;
            off  = int'(addr[win]) & 15;
            for (int k = 0; k < 16; k++) mk[k] = (k >= off) && (k <= off + int'(len[win]));
            if (we[win] && mk != 16'hFFFF) begin
              tag = "R7"; m_state = 2; m_owner = win; m_word = word; m_mask = mk;
            end else begin
              tag = ($countones(valid) > 1) ? "R1" : (we[win] ? "R10" : "R2");
              er[win] = 1'b1;
              do_op(win, word, we[win], wdata[win], we[win] ? "R10" : "R2", nrv);
            end
          end
        end
      end
      1: begin
        tag = ((int'(valid) & ((1 << m_owner) - 1)) != 0) ? "R4" : "R3";
        er[m_owner] = 1'b1;
        do_op(m_owner, m_base + m_beat, we[m_owner], wdata[m_owner], "R3", nrv);
        m_beat++;
        if (m_beat == LB) m_state = 0;
      end
      default: begin
        tag = "R7";
        for (int k = 0; k < 16; k++)
          mg[8*k +: 8] = m_mask[k] ? wdata[m_owner][8*k +: 8] : mmem[m_word][8*k +: 8];
        mmem[m_word] = mg;
        wtag[m_word] = "R6";
        er[m_owner] = 1'b1;
        m_state = 0;
      end
    endcase
    check(ready === er, tag, "ready", DW'(ready), DW'(er));
    for (int p = 0; p < NREQ; p++) begin
      if (er[p]) begin
        if (is_line(p)) begin
          beatc[p]++;
          if (beatc[p] == LB) begin beatc[p] = 0; void'(q[p].pop_front()); end
        end else void'(q[p].pop_front());
      end
    end
    exp_rv = nrv;
  endtask

  function automatic bit pending();
    return (q[0].size() + q[1].size() + q[2].size() + q[3].size()) > 0;
  endfunction

  task automatic drain();
    while (pending()) step();
    repeat (3) step();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NREQ; p++) beatc[p] = 0;
    for (int w = 0; w < DEPTH; w++) wtag[w] = "R3";
    rst_ni = 1'b0; valid = '0; we = '0; addr = '0; len = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // R9: quiet outputs after reset with nothing requested
    check(ready === '0, "R9", "ready after reset", DW'(ready), '0);
    check(rsp_valid === '0, "R9", "rsp_valid after reset", DW'(rsp_valid), '0);

    // fill memory with DMA line writes; junk in the low address bits (R3)
    for (int l = 0; l < DEPTH / LB; l++) push(1, 1'b1, l * 128 + 5 * l + 3, 0, {4{rnd()}});
    drain();

    // all four at once (R1): order io, DMA, data, ifetch
    push(3, 1'b0, 2 * 128, 0, '0);
    push(2, 1'b0, 3 * 16, 0, '0);
    push(1, 1'b0, 1 * 128 + 17, 0, '0);
    push(0, 1'b0, 0, 0, '0);
    drain();

    // higher priority arriving mid-burst (R4)
    push(3, 1'b0, 3 * 128, 0, '0);
    repeat (3) step();
    push(0, 1'b0, 5 * 16, 0, '0);
    push(2, 1'b1, 6 * 16, 15, {4{rnd()}});
    drain();

    // partial writes: inner span, span past lane 15, single top byte, full (R6, R10)
    push(2, 1'b1, 7 * 16 + 3, 3, {4{rnd()}});
    push(2, 1'b1, 8 * 16 + 10, 9, {4{rnd()}});
    push(2, 1'b1, 9 * 16 + 15, 0, {4{rnd()}});
    push(2, 1'b1, 10 * 16, 15, {4{rnd()}});
    push(0, 1'b1, 11 * 16 + 1, 13, {4{rnd()}});
    drain();
    for (int w = 7; w <= 11; w++) push(2, 1'b0, w * 16, 0, '0);
    push(3, 1'b0, 1 * 128, 0, '0);
    drain();

    // request arriving during the read half of a merge must wait (R7)
    push(2, 1'b1, 12 * 16 + 4, 5, {4{rnd()}});
    step();
    push(0, 1'b0, 12 * 16, 0, '0);
    push(1, 1'b0, 1 * 128, 0, '0);
    drain();

    // heavy mixed traffic on all ports (R8)
    for (int i = 0; i < 60; i++) begin
      int p = int'(rnd() % 4);
      push(p, rnd() % 3 == 0, int'(rnd() % (DEPTH * 16)), int'(rnd() % 16), {4{rnd()}});
    end
    drain();
    for (int w = 0; w < DEPTH; w++) push(w % 2 == 0 ? 0 : 2, 1'b0, w * 16, 0, '0);
    drain();

    check(!pending(), "R8", "requests left pending", DW'(pending()), '0);
    finish_run();
  end
endmodule